// File: doc/BRIEF.md
# Antivalent Pair Validity Filter

This block turns a pair of already debounced lines, one carrying a logical bit and the other carrying its complement, into a single decoded bit with a valid flag. A complementary pair is a legal code and gives the bit directly. Both lines low, or both lines high, is an illegal code. An illegal code that lasts only a few sample strobes is treated as a switching transient and hidden: the last good bit is held and the valid flag stays high.

If the illegal code persists beyond a parameterised number of consecutive strobes, the object is declared failed. A bounce fault reported by either upstream debouncer at a strobe also declares it failed. The failed state is latched until reset. On entry, a one-cycle fault event is raised, the valid flag drops and the output bit is forced low. A change between the two legal codes updates the output bit one clock after the strobe and raises a one-cycle change event.

All decisions are taken on cycles where the sample strobe is high. Outputs are registered and appear one clock later.

Top module: `avp_filter`

## Requirements
- R1: During and directly after reset, `bit_out`, `bit_valid`, `fault_evt` and `change_evt` are all 0.
- R2: The first legal code sampled after reset sets `bit_valid` to 1 on the next clock, with `bit_out` equal to `line_true`. Code (1,0) gives 1 and code (0,1) gives 0, written as (line_true, line_comp). This first acquisition raises no `change_evt`.
- R3: On cycles where `smp_stb` is 0, all inputs are ignored, including the bounce-fault flags. On the next clock `bit_out` and `bit_valid` are unchanged, and neither event is raised.
- R4: A sampled legal code whose bit differs from the held bit updates `bit_out` on the next clock and raises `change_evt` for exactly that cycle. A legal code equal to the held bit raises no event.
- R5: Once a bit has been acquired, up to `LIMIT_SAMPLES` consecutive sampled illegal codes, (0,0) or (1,1), leave `bit_valid` at 1 and `bit_out` at the last legal bit.
- R6: The sampled illegal code numbered `LIMIT_SAMPLES`+1 in an unbroken run declares the object failed. On the next clock `bit_valid` and `bit_out` go to 0 and `fault_evt` is 1 for that single cycle.
- R7: A sampled legal code restarts the count of consecutive illegal codes, so illegal runs separated by a legal sample do not add up.
- R8: A sampled strobe with `bnc_flt_true` or `bnc_flt_comp` high declares the object failed, with the same outputs as in R6, whatever the line code.
- R9: The failed state holds until reset: later legal codes, illegal codes or faults change no output and raise no event. After reset the block acquires again as in R2.
- R10: Illegal codes sampled before the first acquisition also count toward the limit. Up to `LIMIT_SAMPLES` of them leave `bit_valid` at 0 without failing. One more declares the object failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe: inputs are evaluated only when high |
| line_true | input | 1 | Debounced line carrying the bit |
| line_comp | input | 1 | Debounced line carrying the complement |
| bnc_flt_true | input | 1 | Bounce fault from the debouncer of `line_true` |
| bnc_flt_comp | input | 1 | Bounce fault from the debouncer of `line_comp` |
| bit_out | output | 1 | Decoded bit, held through masked transients, 0 when failed |
| bit_valid | output | 1 | High while a decoded bit is available and the object has not failed |
| fault_evt | output | 1 | One-cycle pulse on entry into the failed state |
| change_evt | output | 1 | One-cycle pulse when the decoded bit flips |

## Verification
The hardest situation to reach is the exact boundary of the transient window. It takes an unbroken run of exactly `LIMIT_SAMPLES` illegal strobes that must still be masked, then one more that must fail. A near miss, where a single legal strobe splits two long runs, must not fail. The bench lowers the limit to a small value. It then drives runs of illegal codes with every strobe counted: one at the limit, two at the limit split by a legal sample, and one at the limit plus one. It also drives the same run before any bit has been acquired, where masking does not apply.

// File: rtl/avp_pkg.sv
package avp_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HOLD  = 2'd1,
    ST_MASK  = 2'd2,
    ST_DEAD  = 2'd3
  } avp_state_e;

  // A pair is a legal code when the two lines disagree.
  function automatic logic pair_legal(logic t, logic c);
    return t ^ c;
  endfunction

  // Consecutive-illegal counter step, saturating at cap.
  function automatic int unsigned run_step(int unsigned cur, int unsigned cap, logic bad);
    if (!bad) return 0;
    if (cur >= cap) return cap;
    return cur + 1;
  endfunction

  // Run is over the limit when the count already holds 'cap' illegal samples.
  function automatic logic run_over(int unsigned cur, int unsigned cap, logic bad);
    return bad && (cur >= cap);
  endfunction

endpackage

// File: rtl/avp_decode.sv
module avp_decode (
  input  logic line_true,
  input  logic line_comp,
  output logic code_ok,
  output logic code_val
);
  import avp_pkg::*;

  assign code_ok  = pair_legal(line_true, line_comp);
  assign code_val = line_true;

endmodule

// File: rtl/avp_timer.sv
module avp_timer #(
  parameter int unsigned LIMIT_SAMPLES = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic bad,
  output logic expire
);
  import avp_pkg::*;

  localparam int unsigned CNT_W = (LIMIT_SAMPLES < 1) ? 1 : $clog2(LIMIT_SAMPLES + 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (strobe) begin
      run_q <= CNT_W'(run_step(32'(run_q), LIMIT_SAMPLES, bad));
    end
  end

  assign expire = strobe && run_over(32'(run_q), LIMIT_SAMPLES, bad);

endmodule

// File: rtl/avp_ctrl.sv
module avp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic code_ok,
  input  logic code_val,
  input  logic expire,
  input  logic flt_any,
  output logic bit_q,
  output logic valid_q,
  output logic fault_q,
  output logic chg_q
);
  import avp_pkg::*;

  avp_state_e st_q, st_d;
  logic bit_d, valid_d, fault_d, chg_d;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    valid_d = valid_q;
    fault_d = 1'b0;
    chg_d   = 1'b0;
    if (strobe && (st_q != ST_DEAD)) begin
      if (flt_any || expire) begin
        st_d    = ST_DEAD;
        bit_d   = 1'b0;
        valid_d = 1'b0;
        fault_d = 1'b1;
      end else if (code_ok) begin
        chg_d   = (st_q != ST_EMPTY) && (code_val != bit_q);
        bit_d   = code_val;
        valid_d = 1'b1;
        st_d    = ST_HOLD;
      end else if (st_q != ST_EMPTY) begin
        st_d = ST_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_EMPTY;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
      fault_q <= fault_d;
      chg_q   <= chg_d;
    end
  end

endmodule

// File: rtl/avp_filter.sv
module avp_filter #(
  parameter int unsigned LIMIT_SAMPLES = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic line_true,
  input  logic line_comp,
  input  logic bnc_flt_true,
  input  logic bnc_flt_comp,
  output logic bit_out,
  output logic bit_valid,
  output logic fault_evt,
  output logic change_evt
);

  // Named internal events, brought out for the checker.
  logic code_ok_w;
  logic code_val_w;
  logic expire_w;
  logic flt_any_w;

  assign flt_any_w = bnc_flt_true | bnc_flt_comp;

  avp_decode u_decode (
    .line_true (line_true),
    .line_comp (line_comp),
    .code_ok   (code_ok_w),
    .code_val  (code_val_w)
  );

  avp_timer #(.LIMIT_SAMPLES(LIMIT_SAMPLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (smp_stb),
    .bad    (~code_ok_w),
    .expire (expire_w)
  );

  avp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (smp_stb),
    .code_ok  (code_ok_w),
    .code_val (code_val_w),
    .expire   (expire_w),
    .flt_any  (flt_any_w),
    .bit_q    (bit_out),
    .valid_q  (bit_valid),
    .fault_q  (fault_evt),
    .chg_q    (change_evt)
  );

endmodule

// File: rtl/avp_filter_chk.sv
module avp_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_stb,
  input logic bnc_flt_true,
  input logic bnc_flt_comp,
  input logic code_ok,
  input logic expire,
  input logic bit_out,
  input logic bit_valid,
  input logic fault_evt,
  input logic change_evt
);

  logic dead_q;
  always_ff @(posedge clk) begin
    if (!rst_n) dead_q <= 1'b0;
    else        dead_q <= dead_q | fault_evt;
  end

  a_r3_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(bit_out) && $stable(bit_valid) && !change_evt && !fault_evt);

  a_r4_change_flips_bit: assert property (@(posedge clk) disable iff (!rst_n)
    change_evt |-> bit_valid && (bit_out != $past(bit_out)));

  a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !code_ok && !expire && !bnc_flt_true && !bnc_flt_comp && bit_valid
    |=> bit_valid && $stable(bit_out));

  a_r6_expire_fails: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !bit_valid);

  a_r6_fault_drops_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> !bit_valid && !bit_out);

  a_r6_fault_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !fault_evt);

  a_r8_bounce_fails: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && (bnc_flt_true || bnc_flt_comp) |=> !bit_valid);

  a_r9_latched_dead: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |-> !bit_valid && !bit_out && !change_evt && !fault_evt);

endmodule

bind avp_filter avp_filter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_stb      (smp_stb),
  .bnc_flt_true (bnc_flt_true),
  .bnc_flt_comp (bnc_flt_comp),
  .code_ok      (code_ok_w),
  .expire       (expire_w),
  .bit_out      (bit_out),
  .bit_valid    (bit_valid),
  .fault_evt    (fault_evt),
  .change_evt   (change_evt)
);

// File: tb/avp_filter_bench.sv
`timescale 1ns/1ps
module avp_filter_bench;

  localparam int unsigned LIM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic line_true = 1'b0, line_comp = 1'b0;
  logic bnc_flt_true = 1'b0, bnc_flt_comp = 1'b0;
  logic bit_out, bit_valid, fault_evt, change_evt;

  always #10 clk = ~clk;

  avp_filter #(.LIMIT_SAMPLES(LIM)) u_avp_filter (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .line_true(line_true), .line_comp(line_comp),
    .bnc_flt_true(bnc_flt_true), .bnc_flt_comp(bnc_flt_comp),
    .bit_out(bit_out), .bit_valid(bit_valid),
    .fault_evt(fault_evt), .change_evt(change_evt)
  );

  typedef struct {
    logic  v;
    logic  b;
    logic  f;
    logic  c;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_vec = 0;
  int n_bad = 0;

  // Reference model state, kept from the requirements.
  logic m_valid, m_bit, m_dead, m_acq;
  int   m_run;

  task automatic model_reset();
    m_valid = 0; m_bit = 0; m_dead = 0; m_acq = 0; m_run = 0;
  endtask

  task automatic check(input logic ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual v/b/f/c=%b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: compare one expected item per strobe, after the clock edge.
  always @(posedge clk) begin
    if (smp_stb && rst_n) begin
      #5;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        check({bit_valid, bit_out, fault_evt, change_evt} == {e.v, e.b, e.f, e.c}, e.tag,
              {bit_valid, bit_out, fault_evt, change_evt}, {e.v, e.b, e.f, e.c});
      end
    end
  end

  // Driver: one strobe, expected result pushed to the scoreboard.
  task automatic strobe(input logic t, input logic c, input logic bt, input logic bc, input string tag);
    exp_t e;
    logic chg, flt;
    @(negedge clk);
    line_true = t; line_comp = c; bnc_flt_true = bt; bnc_flt_comp = bc;
    chg = 0; flt = 0;
    if (!m_dead) begin
      if (bt || bc || (!(t ^ c) && m_run >= int'(LIM))) begin
        m_dead = 1; m_valid = 0; m_bit = 0; flt = 1;
      end else if (t ^ c) begin
        m_run = 0;
        chg = m_acq && (m_bit != t);
        m_bit = t; m_valid = 1; m_acq = 1;
      end else begin
        m_run++;
      end
    end
    e.v = m_valid; e.b = m_bit; e.f = flt; e.c = chg; e.tag = tag;
    sb.push_back(e);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    bnc_flt_true = 0; bnc_flt_comp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; smp_stb = 0;
    repeat (3) @(negedge clk);
    check({bit_valid, bit_out, fault_evt, change_evt} == 4'b0000, "R1 in reset",
          {bit_valid, bit_out, fault_evt, change_evt}, 4'b0000);
    model_reset();
    rst_n = 1;
    @(negedge clk);
    check({bit_valid, bit_out, fault_evt, change_evt} == 4'b0000, "R1 after reset",
          {bit_valid, bit_out, fault_evt, change_evt}, 4'b0000);
  endtask

  // Inputs churn without a strobe; outputs must stay put.
  task automatic idle_churn(input int n, input string tag);
    logic [3:0] snap;
    snap = {bit_valid, bit_out, 2'b00};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check({bit_valid, bit_out, fault_evt, change_evt} == snap, tag,
            {bit_valid, bit_out, fault_evt, change_evt}, snap);
      line_true = i[0]; line_comp = i[1];
      bnc_flt_true = 1; bnc_flt_comp = i[0];
    end
    @(negedge clk);
    check({bit_valid, bit_out, fault_evt, change_evt} == snap, tag,
          {bit_valid, bit_out, fault_evt, change_evt}, snap);
    bnc_flt_true = 0; bnc_flt_comp = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual run still busy expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    strobe(1, 0, 0, 0, "R2 first acquire 1");
    idle_churn(6, "R3 ignored without strobe");
    strobe(1, 0, 0, 0, "R4 same bit no event");
    strobe(0, 1, 0, 0, "R4 flip to 0");
    strobe(1, 0, 0, 0, "R4 flip to 1");

    for (int i = 0; i < int'(LIM); i++) strobe(0, 0, 0, 0, "R5 mask 00");
    strobe(1, 0, 0, 0, "R7 legal restarts run");
    for (int i = 0; i < int'(LIM); i++) strobe(1, 1, 0, 0, "R7 second run masked");
    strobe(0, 1, 0, 0, "R5 flip after masked run");

    for (int i = 0; i < int'(LIM); i++) strobe(i[0], i[0], 0, 0, "R5 mixed illegal");
    strobe(1, 1, 0, 0, "R6 limit plus one fails");
    @(negedge clk);
    check(fault_evt == 0, "R6 fault single cycle", {3'b0, fault_evt}, 4'b0);
    strobe(1, 0, 0, 0, "R9 stays failed on legal");
    strobe(0, 0, 0, 0, "R9 stays failed on illegal");
    strobe(0, 1, 1, 1, "R9 stays failed on bounce");
    idle_churn(3, "R9 quiet while failed");

    do_reset();
    strobe(0, 1, 0, 0, "R9 reacquire 0 after reset");
    strobe(0, 1, 1, 0, "R8 bounce on true line");

    do_reset();
    strobe(1, 0, 0, 0, "R2 acquire 1");
    strobe(1, 0, 0, 1, "R8 bounce on comp line");

    do_reset();
    strobe(0, 0, 1, 0, "R8 bounce before acquire");

    do_reset();
    for (int i = 0; i < int'(LIM); i++) strobe(1, 1, 0, 0, "R10 early illegal not failed");
    strobe(0, 1, 0, 0, "R10 acquire after early run");

    do_reset();
    for (int i = 0; i < int'(LIM); i++) strobe(0, 0, 0, 0, "R10 early illegal");
    strobe(0, 0, 0, 0, "R10 early limit plus one fails");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule